// File: doc/BRIEF.md
# Sparse XOR-Matrix Uniform Random Bit Generator

This block produces a fresh word of uniform pseudo-random bits on every enabled clock cycle. Its state register moves forward by a fixed sparse transition matrix over GF(2), where addition is XOR and multiplication is AND. Every row of that matrix has only two or three ones, so each next-state bit is one XOR of at most three current-state bits. Every state bit therefore needs one small lookup table feeding one flip-flop, and the path between any two flip-flops is a single logic level. The output matrix is the identity: the random word is the state itself.

The default instance is a 6-bit recurrence with maximum period. Starting from any nonzero state, it passes through all 63 nonzero values before it repeats. The all-zero state maps onto itself and would lock the generator, so the block never enters it. A zero seed is swapped for a fixed nonzero default, and reset loads that same default. A seed load takes priority over an advance in the same cycle. A registered valid flag marks each cycle that follows an advance. The reset is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `sxr_uniform_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rnd_o` equals the default seed 6'b000001 and `valid_o` is low.
- R2: Bit numbering: `rnd_o[k-1]` holds state bit xk. On a cycle with `en_i` high and `load_i` low, the next state is x1'=x2^x3, x2'=x2^x3^x6, x3'=x2^x4, x4'=x1^x5, x5'=x1^x6, x6'=x1^x4^x5.
- R3: On a cycle with both `en_i` and `load_i` low, the state keeps its value.
- R4: On a cycle with `load_i` high and a nonzero `seed_i`, the state takes the value of `seed_i` at that clock edge, whatever the level of `en_i`. Loading takes priority over advancing.
- R5: On a cycle with `load_i` high and `seed_i` equal to zero, the state takes the default seed 6'b000001.
- R6: `rnd_o` is never all zeros.
- R7: From any nonzero state, 63 consecutive advances bring the state back to where it started. Each of the 63 nonzero values appears exactly once along the way.
- R8: `valid_o` is high in the cycle after an edge where the state advanced (`en_i` high, `load_i` low). It is low after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the state by one step |
| load_i | input | 1 | Replace the state with the seed |
| seed_i | input | 6 | Seed value; zero selects the default seed |
| rnd_o | output | 6 | Random word, equal to the state |
| valid_o | output | 1 | High after an advance |

## Verification
Seed loading and advancing can both be requested in the same cycle. The bench drives `load_i` and `en_i` high together, once with a nonzero seed and once with a zero seed. It checks that the state afterwards is exactly the loaded value or the default seed, and not a stepped value, and that `valid_o` stays low after that edge. Before these cases, the bench runs every one of the 63 nonzero seeds through a full period and compares each step against an equation model.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  // Width of the default instance
  localparam int SXR_W = 6;

  typedef logic [SXR_W-1:0] sxr_word_t;

  // Nonzero seed used after reset and in place of a zero seed
  localparam sxr_word_t SXR_DEF_SEED = 6'b000001;

  // Row masks of the transition matrix; row k selects the current-state
  // bits that are XORed into next-state bit k (bit 0 = x1).
  localparam logic [SXR_W-1:0][SXR_W-1:0] SXR_DEF_TAPS = {
    6'b011001,   // x6' = x1^x4^x5
    6'b100001,   // x5' = x1^x6
    6'b010001,   // x4' = x1^x5
    6'b001010,   // x3' = x2^x4
    6'b100110,   // x2' = x2^x3^x6
    6'b000110    // x1' = x2^x3
  };
endpackage

// File: rtl/sxr_row_xor.sv
module sxr_row_xor #(
  parameter int            W    = 6,
  parameter logic [W-1:0]  MASK = '0
) (
  input  logic [W-1:0] state_i,
  output logic         bit_o
);
  // One XOR level over the bits selected by this row of the matrix
  assign bit_o = ^(state_i & MASK);
endmodule

// File: rtl/sxr_seed_sel.sv
module sxr_seed_sel #(
  parameter int           W        = 6,
  parameter logic [W-1:0] DEF_SEED = 1
) (
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] seed_o
);
  // A zero seed would lock the generator; substitute the default
  always_comb begin
    if (seed_i == '0) seed_o = DEF_SEED;
    else              seed_o = seed_i;
  end
endmodule

// File: rtl/sxr_uniform_gen.sv
module sxr_uniform_gen
  import sxr_pkg::*;
#(
  parameter int                    W        = SXR_W,
  parameter logic [W-1:0][W-1:0]   TAPS     = SXR_DEF_TAPS,
  parameter logic [W-1:0]          DEF_SEED = SXR_DEF_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] rnd_o,
  output logic         valid_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] step_w;
  logic [W-1:0] seed_w;
  logic         state_ce;
  logic         valid_d;
  logic         valid_q;

  // One row of the transition matrix per state bit
  for (genvar g = 0; g < W; g++) begin : g_row
    sxr_row_xor #(
      .W    (W),
      .MASK (TAPS[g])
    ) u_row (
      .state_i (state_q),
      .bit_o   (step_w[g])
    );
  end

  sxr_seed_sel #(
    .W        (W),
    .DEF_SEED (DEF_SEED)
  ) u_seed (
    .seed_i (seed_i),
    .seed_o (seed_w)
  );

  // Next-state selection: load has priority over advance
  always_comb begin
    state_ce = load_i | en_i;
    valid_d  = 1'b0;
    state_d  = state_q;
    if (load_i) begin
      state_d = seed_w;
    end else if (en_i) begin
      state_d = step_w;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEF_SEED;
    end else if (state_ce) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign rnd_o   = state_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sxr_uniform_gen_chk.sv
module sxr_uniform_gen_chk #(
  parameter int           W        = 6,
  parameter logic [W-1:0] DEF_SEED = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         load_i,
  input logic [W-1:0] seed_i,
  input logic [W-1:0] rnd_o,
  input logic         valid_o
);
  // R6: the locking all-zero state is never reached
  p_never_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_o != '0);

  // R3: idle cycles keep the state
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(rnd_o));

  // R4: a nonzero seed is taken exactly
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && seed_i != '0) |=> (rnd_o == $past(seed_i)));

  // R5: a zero seed becomes the default
  p_zero_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && seed_i == '0) |=> (rnd_o == DEF_SEED));

  // R2: an advance always moves a nonzero state (no other fixed point)
  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i) |=> (rnd_o != $past(rnd_o)));

  // R8: valid follows advances only
  p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i) |=> valid_o);
  p_valid_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && !load_i) |=> !valid_o);
endmodule

bind sxr_uniform_gen sxr_uniform_gen_chk #(
  .W        (W),
  .DEF_SEED (DEF_SEED)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .load_i  (load_i),
  .seed_i  (seed_i),
  .rnd_o   (rnd_o),
  .valid_o (valid_o)
);

// File: tb/tb_sxr_uniform_gen.sv
module tb_sxr_uniform_gen;
  logic       clk;
  logic       rst_n;
  logic       en_i;
  logic       load_i;
  logic [5:0] seed_i;
  logic [5:0] rnd_o;
  logic       valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  sxr_uniform_gen dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .rnd_o   (rnd_o),
    .valid_o (valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // Equation model, bit k-1 holds xk
  function automatic logic [5:0] model_step(input logic [5:0] s);
    logic [5:0] n;
    n[0] = s[1] ^ s[2];
    n[1] = s[1] ^ s[2] ^ s[5];
    n[2] = s[1] ^ s[3];
    n[3] = s[0] ^ s[4];
    n[4] = s[0] ^ s[5];
    n[5] = s[0] ^ s[3] ^ s[4];
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [5:0] act,
                     input logic [5:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the rising edge
  task automatic cyc(input logic en, input logic ld, input logic [5:0] sd);
    @(negedge clk);
    en_i   = en;
    load_i = ld;
    seed_i = sd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0]  m;
    logic [5:0]  prev;
    logic [63:0] seen;
    rst_n  = 1'b0;
    en_i   = 1'b0;
    load_i = 1'b0;
    seed_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(rnd_o == 6'b000001, "R1 reset state", rnd_o, 6'b000001);
    chk(valid_o == 1'b0, "R1 reset valid", {5'b0, valid_o}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rnd_o == 6'b000001, "R1 state after release", rnd_o, 6'b000001);
    chk(valid_o == 1'b0, "R1 valid after release", {5'b0, valid_o}, 6'b0);

    // Exhaustive sweep: every nonzero seed through a full period
    for (int s = 1; s < 64; s++) begin
      cyc(1'b0, 1'b1, 6'(s));
      chk(rnd_o == 6'(s), "R4 seed load", rnd_o, 6'(s));
      chk(valid_o == 1'b0, "R8 no valid after load", {5'b0, valid_o}, 6'b0);
      m    = 6'(s);
      seen = '0;
      seen[s] = 1'b1;
      for (int k = 1; k <= 63; k++) begin
        cyc(1'b1, 1'b0, 6'b0);
        m = model_step(m);
        chk(rnd_o == m, "R2 step equations", rnd_o, m);
        chk(rnd_o != 6'b0, "R6 nonzero state", rnd_o, 6'b111111);
        chk(valid_o == 1'b1, "R8 valid after advance", {5'b0, valid_o}, 6'b1);
        if (k < 63) begin
          chk(seen[rnd_o] == 1'b0, "R7 value repeated early", rnd_o, 6'b0);
          seen[rnd_o] = 1'b1;
        end
      end
      chk(rnd_o == 6'(s), "R7 period 63 return", rnd_o, 6'(s));
      chk(seen[63:1] == {63{1'b1}}, "R7 all nonzero values seen",
          6'($countones(seen[63:1])), 6'd63);
    end

    // Hold with enable low
    cyc(1'b0, 1'b1, 6'b101101);
    prev = rnd_o;
    for (int k = 0; k < 5; k++) begin
      cyc(1'b0, 1'b0, 6'b010101);
      chk(rnd_o == prev, "R3 hold when idle", rnd_o, prev);
      chk(valid_o == 1'b0, "R8 no valid when idle", {5'b0, valid_o}, 6'b0);
    end

    // Load and enable in the same cycle: load wins
    cyc(1'b1, 1'b1, 6'b101010);
    chk(rnd_o == 6'b101010, "R4 load wins over enable", rnd_o, 6'b101010);
    chk(valid_o == 1'b0, "R8 no valid on load with enable", {5'b0, valid_o}, 6'b0);

    // Zero seed, with and without enable
    cyc(1'b1, 1'b1, 6'b0);
    chk(rnd_o == 6'b000001, "R5 zero seed with enable", rnd_o, 6'b000001);
    chk(valid_o == 1'b0, "R8 no valid on zero seed load", {5'b0, valid_o}, 6'b0);
    cyc(1'b1, 1'b0, 6'b0);
    chk(rnd_o == model_step(6'b000001), "R2 step after zero seed",
        rnd_o, model_step(6'b000001));
    cyc(1'b0, 1'b1, 6'b0);
    chk(rnd_o == 6'b000001, "R5 zero seed without enable", rnd_o, 6'b000001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule